// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of an 8-bit converter with eight analog inputs. A request pulse, together with a channel number, starts one conversion. The block captures the channel and drives the input multiplexer select from that captured value. It derives a converter clock enable at one quarter of the system clock and runs a fixed frame of 31 converter periods. The first 10 periods hold the sample-enable high. The next 8 periods each test one bit, starting at the MSB. The remaining 13 periods are settle and latch time.

During each trial the block presents a trial code to the external DAC and reads back a single comparator bit. That bit is high when the held input is at or above the trial code. At the end of the frame the accumulated code is copied into a result register, and a sticky done flag rises. The done flag serves as the interrupt. It stays set until a clear pulse removes it.

The result is a held register and not a stream, so the block has no valid/ready pair. Control and status use plain level or pulse pins.

Top module: `adcseq_top`

## Requirements
- R1: After reset, busy, done_irq, sample_en, result and trial_code are all zero.
- R2: A start_req seen while idle captures start_chan. mux_sel equals that channel throughout the conversion and keeps it afterwards.
- R3: busy rises on the clock edge that accepts a start and stays high for exactly 124 system clock cycles (31 converter periods of 4 cycles each). The result is latched on the edge where busy falls.
- R4: sample_en is high for exactly the first 40 system cycles of the conversion (10 converter periods) and is never high while idle.
- R5: In converter period 10+k (k = 0..7) of a frame, trial_code equals the bits already decided above bit 7-k, with bit 7-k set and all lower bits clear. Bit 7 is tested first and bit 0 last.
- R6: A trial bit is kept when cmp_ge is 1 at the end of its period. With an ideal comparator the result equals the input code for every value from 00h to FFh.
- R7: A start_req while busy is ignored. The channel, the frame length and the result are the same as if the request had not been made.
- R8: done_irq goes to 1 on the latch edge and stays 1 until a cycle with done_clr high. If done_clr arrives on the latch edge itself, done_irq stays set.
- R9: result changes only on a latch edge. It holds its value while idle and while a new conversion runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_req | input | 1 | Conversion request pulse |
| start_chan | input | 3 | Channel number, sampled with start_req |
| done_clr | input | 1 | Write-1 clear of the done flag |
| cmp_ge | input | 1 | Comparator: held input is at or above trial_code |
| mux_sel | output | 3 | Analog multiplexer select |
| sample_en | output | 1 | Sample-and-hold enable |
| trial_code | output | 8 | Code driven to the DAC |
| busy | output | 1 | Conversion in progress |
| done_irq | output | 1 | Sticky completion flag / interrupt |
| result | output | 8 | Last latched conversion result |

## Verification
The assertions assume that cmp_ge depends only on trial_code and a held analog value, and that it settles within the same cycle. They also assume start_chan is valid whenever start_req is high. The bench models the comparator as a combinational compare of a stored 8-bit code for the selected channel against trial_code. It changes those stored codes only while the block is idle, so the held input never moves inside a frame. Requests while busy are issued with a different channel whose stored code differs, which makes any wrongful acceptance visible in mux_sel, the frame length or the result.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  localparam int RES_BITS   = 8;
  localparam int NUM_CHAN   = 8;
  localparam int PRESCALE   = 4;
  localparam int FRAME_LEN  = 31;
  localparam int SAMPLE_LEN = 10;

  localparam int CHAN_W = $clog2(NUM_CHAN);

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SAMPLE = 2'd1,
    PH_TRIAL  = 2'd2,
    PH_SETTLE = 2'd3
  } phase_e;
endpackage

// File: rtl/adcseq_prescale.sv
module adcseq_prescale #(
  parameter int PRESCALE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic tick
);
  localparam int DW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [DW-1:0] LAST = DW'(PRESCALE - 1);

  logic [DW-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (clr) begin
      div_q <= '0;
    end else if (run) begin
      div_q <= (div_q == LAST) ? '0 : div_q + 1'b1;
    end
  end

  assign tick = run && (div_q == LAST);

  generate
    if (PRESCALE > 1) begin : g_space
      // R3: converter ticks are never on adjacent system cycles
      a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/adcseq_frame.sv
module adcseq_frame
  import adcseq_pkg::*;
#(
  parameter int FRAME_LEN  = 31,
  parameter int SAMPLE_LEN = 10,
  parameter int RES_BITS   = 8,
  parameter int PRESCALE   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_go,
  input  logic tick,
  output logic busy,
  output phase_e phase,
  output logic [$clog2(RES_BITS)-1:0] trial_idx,
  output logic trial_tick,
  output logic frame_end
);
  localparam int PER_W = $clog2(FRAME_LEN);
  localparam int IDX_W = $clog2(RES_BITS);
  localparam logic [PER_W-1:0] P_LAST   = PER_W'(FRAME_LEN - 1);
  localparam logic [PER_W-1:0] P_TRIAL0 = PER_W'(SAMPLE_LEN);
  localparam logic [PER_W-1:0] P_SETTLE = PER_W'(SAMPLE_LEN + RES_BITS);
  localparam int LEN_W = $clog2(FRAME_LEN * PRESCALE + 1) + 1;

  logic [PER_W-1:0] period_q;
  logic             busy_q;
  logic [PER_W-1:0] rel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      period_q <= '0;
    end else if (start_go) begin
      busy_q   <= 1'b1;
      period_q <= '0;
    end else if (busy_q && tick) begin
      if (period_q == P_LAST) begin
        busy_q   <= 1'b0;
        period_q <= '0;
      end else begin
        period_q <= period_q + 1'b1;
      end
    end
  end

  always_comb begin
    if (!busy_q)                 phase = PH_IDLE;
    else if (period_q < P_TRIAL0) phase = PH_SAMPLE;
    else if (period_q < P_SETTLE) phase = PH_TRIAL;
    else                          phase = PH_SETTLE;
  end

  assign rel        = period_q - P_TRIAL0;
  assign trial_idx  = rel[IDX_W-1:0];
  assign busy       = busy_q;
  assign trial_tick = tick && (phase == PH_TRIAL);
  assign frame_end  = busy_q && tick && (period_q == P_LAST);

  // cycle counter used only by the frame-length check
  logic [LEN_W-1:0] len_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        len_q <= '0;
    else if (start_go) len_q <= '0;
    else if (busy_q)   len_q <= len_q + 1'b1;
  end

  a_r3_frame_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> (len_q == LEN_W'(FRAME_LEN * PRESCALE)));

  a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !frame_end) |=> busy_q);
endmodule

// File: rtl/adcseq_sar.sv
module adcseq_sar #(
  parameter int RES_BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic trial_en,
  input  logic settle_en,
  input  logic trial_tick,
  input  logic [$clog2(RES_BITS)-1:0] trial_idx,
  input  logic cmp_ge,
  output logic [RES_BITS-1:0] trial_code,
  output logic [RES_BITS-1:0] code_out
);
  localparam logic [RES_BITS-1:0] MSB = {1'b1, {(RES_BITS-1){1'b0}}};

  logic [RES_BITS-1:0] sar_q;
  logic [RES_BITS-1:0] probe;

  assign probe = MSB >> trial_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    sar_q <= '0;
    else if (clr)                  sar_q <= '0;
    else if (trial_tick && cmp_ge) sar_q <= sar_q | probe;
  end

  always_comb begin
    if (trial_en)       trial_code = sar_q | probe;
    else if (settle_en) trial_code = sar_q;
    else                trial_code = '0;
  end

  assign code_out = sar_q;

  // R5: the first trial starts from a cleared code
  a_r5_msb_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (trial_tick && trial_idx == '0) |-> (sar_q == '0));

  // R6: a comparator hit keeps the tested bit
  a_r6_keep_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (trial_tick && cmp_ge) |=> ((sar_q & $past(probe)) != '0));
endmodule

// File: rtl/adcseq_top.sv
module adcseq_top
  import adcseq_pkg::*;
#(
  parameter int RES_BITS   = adcseq_pkg::RES_BITS,
  parameter int NUM_CHAN   = adcseq_pkg::NUM_CHAN,
  parameter int PRESCALE   = adcseq_pkg::PRESCALE,
  parameter int FRAME_LEN  = adcseq_pkg::FRAME_LEN,
  parameter int SAMPLE_LEN = adcseq_pkg::SAMPLE_LEN,
  localparam int CW = $clog2(NUM_CHAN),
  localparam int IW = $clog2(RES_BITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_req,
  input  logic [CW-1:0] start_chan,
  input  logic          done_clr,
  input  logic          cmp_ge,
  output logic [CW-1:0] mux_sel,
  output logic          sample_en,
  output logic [RES_BITS-1:0] trial_code,
  output logic          busy,
  output logic          done_irq,
  output logic [RES_BITS-1:0] result
);
  logic          start_go;
  logic          tick;
  logic          frame_end;
  logic          trial_tick;
  phase_e        phase;
  logic [IW-1:0] trial_idx;
  logic [RES_BITS-1:0] sar_code;
  logic [CW-1:0] chan_q;
  logic [RES_BITS-1:0] result_q;
  logic          done_q;

  assign start_go = start_req && !busy;

  adcseq_prescale #(.PRESCALE(PRESCALE)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(start_go), .run(busy), .tick(tick)
  );

  adcseq_frame #(
    .FRAME_LEN(FRAME_LEN), .SAMPLE_LEN(SAMPLE_LEN),
    .RES_BITS(RES_BITS), .PRESCALE(PRESCALE)
  ) u_frame (
    .clk(clk), .rst_n(rst_n), .start_go(start_go), .tick(tick),
    .busy(busy), .phase(phase), .trial_idx(trial_idx),
    .trial_tick(trial_tick), .frame_end(frame_end)
  );

  adcseq_sar #(.RES_BITS(RES_BITS)) u_sar (
    .clk(clk), .rst_n(rst_n), .clr(start_go),
    .trial_en(phase == PH_TRIAL), .settle_en(phase == PH_SETTLE),
    .trial_tick(trial_tick), .trial_idx(trial_idx), .cmp_ge(cmp_ge),
    .trial_code(trial_code), .code_out(sar_code)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q   <= '0;
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      if (start_go) chan_q <= start_chan;
      if (frame_end) begin
        result_q <= sar_code;
        done_q   <= 1'b1;
      end else if (done_clr) begin
        done_q <= 1'b0;
      end
    end
  end

  assign mux_sel   = chan_q;
  assign sample_en = (phase == PH_SAMPLE);
  assign done_irq  = done_q;
  assign result    = result_q;

  a_r2_chan_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mux_sel));

  a_r4_sample_busy: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |-> busy);

  a_r8_done_on_latch: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_irq);

  a_r9_result_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(result));

  a_r9_result_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(result) || $fell(busy)));
endmodule

// File: tb/adcseq_top_tb.sv
module adcseq_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int FRAME_CYC  = 124;
  localparam int SAMPLE_CYC = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_req = 1'b0;
  logic [2:0] start_chan = '0;
  logic       done_clr = 1'b0;
  logic       cmp_ge;
  logic [2:0] mux_sel;
  logic       sample_en;
  logic [7:0] trial_code;
  logic       busy;
  logic       done_irq;
  logic [7:0] result;

  logic [7:0] analog [8];
  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign cmp_ge = (analog[mux_sel] >= trial_code);

  adcseq_top u_dut (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .start_chan(start_chan),
    .done_clr(done_clr), .cmp_ge(cmp_ge), .mux_sel(mux_sel),
    .sample_en(sample_en), .trial_code(trial_code), .busy(busy),
    .done_irq(done_irq), .result(result)
  );

  function automatic logic [7:0] exp_trial(input logic [7:0] code, input int k);
    logic [7:0] upper = 8'hFF << (8 - k);
    if (k == 0) upper = 8'h00;
    return (code & upper) | (8'h80 >> k);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic clear_done();
    done_clr = 1'b1;
    @(negedge clk);
    done_clr = 1'b0;
    chk("R8 clear", done_irq, 0);
  endtask

  task automatic run_conv(input int ch, input bit poke, input bit clr_end);
    logic [7:0] expc = analog[ch];
    logic [7:0] prev_res = result;
    int blen = 0, slen = 0, bad_mux = 0, bad_trial = 0, late_s = 0, res_moved = 0;
    start_req  = 1'b1;
    start_chan = 3'(ch);
    @(negedge clk);
    for (int i = 0; i < 200; i++) begin
      if (!busy) break;
      blen++;
      if (sample_en) slen++;
      if (sample_en && i >= SAMPLE_CYC) late_s++;
      if (mux_sel != 3'(ch)) bad_mux++;
      if (result != prev_res) res_moved++;
      if ((i % 4 == 0) && (i / 4 >= 10) && (i / 4 < 18)) begin
        if (trial_code != exp_trial(expc, i / 4 - 10)) begin
          bad_trial++;
          $display("FAIL R5 period=%0d actual=%0h expected=%0h",
                   i / 4, trial_code, exp_trial(expc, i / 4 - 10));
        end
      end
      if (poke && i == 50) begin
        start_req  = 1'b1;
        start_chan = 3'(ch) ^ 3'h5;
      end else begin
        start_req = 1'b0;
      end
      done_clr = (clr_end && i == FRAME_CYC - 1);
      @(negedge clk);
    end
    start_req = 1'b0;
    done_clr  = 1'b0;
    checks++;
    if (bad_trial != 0) failures++;
    chk("R3 busy length", blen, FRAME_CYC);
    chk("R4 sample length", slen, SAMPLE_CYC);
    chk("R4 no late sample", late_s, 0);
    chk(poke ? "R7 channel held" : "R2 channel held", bad_mux, 0);
    chk("R9 result held while busy", res_moved, 0);
    chk(poke ? "R7 result of first channel" : "R6 result", result, expc);
    chk(clr_end ? "R8 set wins over clear" : "R8 done set", done_irq, 1);
    chk("R2 mux after frame", mux_sel, ch);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    if (!finished) begin
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    for (int c = 0; c < 8; c++) analog[c] = 8'(c * 37 + 11);
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 done", done_irq, 0);
    chk("R1 sample_en", sample_en, 0);
    chk("R1 result", result, 0);
    chk("R1 trial_code", trial_code, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed corners
    analog[0] = 8'h00; run_conv(0, 0, 0); clear_done();
    analog[7] = 8'hFF; run_conv(7, 0, 0); clear_done();
    analog[3] = 8'h80; run_conv(3, 0, 0); clear_done();
    analog[4] = 8'h7F; run_conv(4, 0, 0); clear_done();
    analog[5] = 8'h01; run_conv(5, 0, 0);
    repeat (5) @(negedge clk);
    chk("R8 sticky", done_irq, 1);
    chk("R9 result idle", result, 8'h01);
    clear_done();

    // R7: request during busy with a distinct channel and code
    analog[2] = 8'h5A; analog[7] = 8'hC3;
    run_conv(2, 1, 0); clear_done();

    // R8: clear on the latch edge
    analog[6] = 8'hA5;
    run_conv(6, 0, 1);
    clear_done();

    // random conversions
    for (int n = 0; n < 24; n++) begin
      int ch = int'($urandom_range(7, 0));
      analog[ch] = 8'($urandom_range(255, 0));
      run_conv(ch, n % 5 == 0, 0);
      if (n % 2 == 0) clear_done();
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule